// File: doc/BRIEF.md
# Prioritized Edge Interrupt Controller

The block gathers sixteen numbered interrupt sources and one bypass line and turns each change on them into a six-bit priority code for the processor. Each source has a programmable three-bit level. A rising edge on source `s` marks it pending, which clears its bit in an active-low pending register. The rise then produces code `16+s`, but only if the level of that source is strictly greater than a 32-bit threshold register. A rise on the bypass line always produces code 32. A fall on any line produces code 0, which tells the processor that the interrupt has gone away.

Software reaches the pending, threshold and level registers through a byte-wide bus over a 32-byte window. The source numbering is fixed. Sources 1 to 7 of the external pins take indices 0 to 6. Indices 7 to 10 are the DMA channels in the order 3, 2, 1, 0. Indices 11 and 12 are serial ports 0 and 1. Indices 13 to 15 are timers 0, 1 and 2. Edges are detected inside the block against the input values registered on the previous clock. The block issues at most one code per cycle.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the following values hold. The pending register reads 0x0000FFFF, with byte 0 = 0xFF, byte 1 = 0xFF and bytes 2 and 3 = 0x00. The threshold register and all level registers read 0. `codeValid` is 0.
- R2: The register bytes sit at these addresses. The pending register occupies addresses 0 to 3 as a little-endian word, and its bits 15:0 hold sources 15 to 0. The threshold is a 32-bit little-endian word at addresses 4 to 7. The level of source `s` is held in bits 2:0 of the byte at address `16+s`, and bits 7:3 of that byte read 0. Every byte is written and read on its own.
- R3: Addresses 8 to 15 read 0, and a write to them changes no register.
- R4: A rising edge on source `s` clears pending bit `s` to 0, whatever its level. Software may write the bit back to 1.
- R5: A rising edge on source `s` whose level is strictly greater than the threshold produces a one-cycle pulse on `codeValid` with `codeOut = 16+s`. This happens on the clock edge that first samples the new input value. A rise whose level does not exceed the threshold produces no pulse.
- R6: A rising edge on `bypassIn` produces a pulse with `codeOut = 32`, whatever the registers hold.
- R7: A falling edge on `bypassIn` or on any source produces a pulse with `codeOut = 0`.
- R8: When several lines change in one cycle, the bypass line wins. After it comes the lowest-index source that has a fall or a qualifying rise. Only one code is issued, but every rising source still clears its pending bit.
- R9: When a bus write to a pending-register byte and a rising edge hit the same bit in one cycle, the bit ends at 0. The other bits of that byte take the written value.
- R10: `busRdData` loads the addressed byte on the clock edge where `busRdEn` is 1, and holds its value otherwise.
- R11: The threshold compare uses all 32 bits. A threshold of 7 or more blocks every source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcIn | input | 16 | Interrupt source levels, index 0 to 15 |
| bypassIn | input | 1 | Bypass interrupt line, code 32 |
| busAddr | input | 5 | Byte address inside the register window |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 8 | Write data byte |
| busRdEn | input | 1 | Read strobe |
| busRdData | output | 8 | Registered read data byte |
| codeOut | output | 6 | Priority code of the current event |
| codeValid | output | 1 | One-cycle event pulse |

## Verification
The bench builds the block with the default package values: sixteen sources, three-bit levels, a five-bit address and byte-wide data. With these values the full window of 32 addresses can be swept after reset and after random traffic. The sixteen-way priority scan is exercised with several sources changing at once. Threshold values above the largest level are also reachable, so the full-width compare is tested.

// File: rtl/irq_pkg.sv
package irq_pkg;
  parameter int IRQ_SRCS = 16;
  parameter int LVL_W = 3;
  parameter int CODE_W = 6;
  parameter int ADDR_W = 5;
  parameter int BYTE_W = 8;
  localparam int CODE_BASE = 16;
  localparam int BYPASS_CODE = 32;

  typedef struct packed {
    logic [IRQ_SRCS-1:0] pendClr;
  } ctlStrobe_t;
endpackage

// File: rtl/irq_regs.sv
module irq_regs
  import irq_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobe_t          strobe,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWrEn,
  input  logic [BYTE_W-1:0]   busWrData,
  input  logic                busRdEn,
  output logic [BYTE_W-1:0]   busRdData,
  output logic [IRQ_SRCS-1:0] srcAbove
);
  localparam int LANE_W = 2;
  localparam int WORD_W = ADDR_W - LANE_W;
  localparam int LANES = 1 << LANE_W;
  localparam int MASK_W = LANES * BYTE_W;
  localparam int STAT_BYTES = IRQ_SRCS / BYTE_W;
  localparam int IDX_W = $clog2(IRQ_SRCS);
  localparam logic [WORD_W-1:0] STAT_WORD = '0;
  localparam logic [WORD_W-1:0] MASK_WORD = WORD_W'(1);

  logic [WORD_W-1:0] word;
  logic [LANE_W-1:0] lane;
  logic lvlSel;
  logic [IDX_W-1:0] lvlIdx;
  logic [IRQ_SRCS-1:0] pendQ, pendWr, pendD;
  logic [MASK_W-1:0] maskQ;
  logic [IRQ_SRCS-1:0][LVL_W-1:0] lvlQ;
  logic [BYTE_W-1:0] rdNext;

  assign word   = busAddr[ADDR_W-1:LANE_W];
  assign lane   = busAddr[LANE_W-1:0];
  assign lvlSel = busAddr[ADDR_W-1];
  assign lvlIdx = busAddr[IDX_W-1:0];

  // pending register: bus write first, hardware clear on top
  always_comb begin
    pendWr = pendQ;
    if (busWrEn && !lvlSel && word == STAT_WORD) begin
      for (int b = 0; b < STAT_BYTES; b++)
        if (lane == LANE_W'(b)) pendWr[b*BYTE_W +: BYTE_W] = busWrData;
    end
  end
  assign pendD = pendWr & ~strobe.pendClr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendQ <= '1;
    else       pendQ <= pendD;
  end

  genvar gb, gs;
  generate
    for (gb = 0; gb < LANES; gb++) begin : g_maskLane
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) maskQ[gb*BYTE_W +: BYTE_W] <= '0;
        else if (busWrEn && !lvlSel && word == MASK_WORD && lane == LANE_W'(gb))
          maskQ[gb*BYTE_W +: BYTE_W] <= busWrData;
      end
    end
    for (gs = 0; gs < IRQ_SRCS; gs++) begin : g_level
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) lvlQ[gs] <= '0;
        else if (busWrEn && lvlSel && lvlIdx == IDX_W'(gs))
          lvlQ[gs] <= busWrData[LVL_W-1:0];
      end
      assign srcAbove[gs] = MASK_W'(lvlQ[gs]) > maskQ;
    end
  endgenerate

  always_comb begin
    rdNext = '0;
    if (lvlSel) rdNext = BYTE_W'(lvlQ[lvlIdx]);
    else if (word == STAT_WORD) begin
      for (int b = 0; b < STAT_BYTES; b++)
        if (lane == LANE_W'(b)) rdNext = pendQ[b*BYTE_W +: BYTE_W];
    end else if (word == MASK_WORD) begin
      for (int b = 0; b < LANES; b++)
        if (lane == LANE_W'(b)) rdNext = maskQ[b*BYTE_W +: BYTE_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        busRdData <= '0;
    else if (busRdEn) busRdData <= rdNext;
  end

  // R4
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|strobe.pendClr) |=> ((pendQ & $past(strobe.pendClr)) == '0));

  // R3
  unmapped_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && !lvlSel && word != STAT_WORD && word != MASK_WORD)
      |=> ($stable(maskQ) && $stable(lvlQ)));

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busRdEn |=> $stable(busRdData));
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [IRQ_SRCS-1:0] srcIn,
  input  logic                bypassIn,
  input  logic [IRQ_SRCS-1:0] srcAbove,
  output ctlStrobe_t          strobe,
  output logic [CODE_W-1:0]   codeOut,
  output logic                codeValid
);
  logic [IRQ_SRCS-1:0] prevSrc, rise, fall, evt;
  logic prevByp, bypRise, bypFall;
  logic selValid;
  logic [CODE_W-1:0] selCode;

  assign rise    = srcIn & ~prevSrc;
  assign fall    = ~srcIn & prevSrc;
  assign bypRise = bypassIn & ~prevByp;
  assign bypFall = ~bypassIn & prevByp;
  assign evt     = fall | (rise & srcAbove);
  assign strobe.pendClr = rise;

  // lowest index wins: scan from the top so the last hit stays
  always_comb begin
    selValid = 1'b0;
    selCode  = '0;
    for (int s = IRQ_SRCS - 1; s >= 0; s--) begin
      if (evt[s]) begin
        selValid = 1'b1;
        selCode  = fall[s] ? '0 : CODE_W'(CODE_BASE + s);
      end
    end
    if (bypRise || bypFall) begin
      selValid = 1'b1;
      selCode  = bypRise ? CODE_W'(BYPASS_CODE) : '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevSrc   <= '0;
      prevByp   <= 1'b0;
      codeOut   <= '0;
      codeValid <= 1'b0;
    end else begin
      prevSrc   <= srcIn;
      prevByp   <= bypassIn;
      codeValid <= selValid;
      if (selValid) codeOut <= selCode;
    end
  end

  // R6
  bypass_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bypassIn && !prevByp) |=> (codeValid && codeOut == CODE_W'(BYPASS_CODE)));

  // R7
  bypass_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!bypassIn && prevByp) |=> (codeValid && codeOut == '0));

  // R5
  code_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    codeValid |-> (codeOut == '0 || codeOut == CODE_W'(BYPASS_CODE) ||
                   (codeOut >= CODE_W'(CODE_BASE) && codeOut < CODE_W'(BYPASS_CODE))));

  // R8
  bypass_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (codeValid && codeOut >= CODE_W'(CODE_BASE) && codeOut < CODE_W'(BYPASS_CODE))
      |-> !$past(bypassIn ^ prevByp));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [IRQ_SRCS-1:0] srcIn,
  input  logic                bypassIn,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWrEn,
  input  logic [BYTE_W-1:0]   busWrData,
  input  logic                busRdEn,
  output logic [BYTE_W-1:0]   busRdData,
  output logic [CODE_W-1:0]   codeOut,
  output logic                codeValid
);
  ctlStrobe_t strobe;
  logic [IRQ_SRCS-1:0] srcAbove;

  irq_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .bypassIn(bypassIn),
    .srcAbove(srcAbove), .strobe(strobe),
    .codeOut(codeOut), .codeValid(codeValid)
  );

  irq_regs i_regs (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdEn(busRdEn), .busRdData(busRdData), .srcAbove(srcAbove)
  );
endmodule

// File: tb/test_prio_irq_ctrl.sv
`timescale 1ns/1ps
module test_prio_irq_ctrl;
  logic clk = 0, rstN = 0;
  logic [15:0] srcIn = '0;
  logic bypassIn = 0;
  logic [4:0] busAddr = '0;
  logic busWrEn = 0, busRdEn = 0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic [5:0] codeOut;
  logic codeValid;

  int nChecks = 0, nFail = 0;
  logic [15:0] mStatus = 16'hFFFF;
  logic [31:0] mMask = '0;
  logic [2:0]  mLvl [16];
  logic [15:0] mPrev = '0;
  logic        mPrevByp = 0;

  always #2 clk = ~clk;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .bypassIn(bypassIn),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdEn(busRdEn), .busRdData(busRdData),
    .codeOut(codeOut), .codeValid(codeValid)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] modelRead(input logic [4:0] a);
    if (a[4]) return {5'b0, mLvl[a[3:0]]};
    case (a[3:2])
      2'd0: return (a[1:0] == 0) ? mStatus[7:0] : (a[1:0] == 1) ? mStatus[15:8] : 8'h00;
      2'd1: return mMask[a[1:0]*8 +: 8];
      default: return 8'h00;
    endcase
  endfunction

  function automatic void modelWrite(input logic [4:0] a, input logic [7:0] d);
    if (a[4]) mLvl[a[3:0]] = d[2:0];
    else if (a[3:2] == 0 && a[1:0] < 2) mStatus[a[1:0]*8 +: 8] = d;
    else if (a[3:2] == 1) mMask[a[1:0]*8 +: 8] = d;
  endfunction

  // expected event for a new input pattern, from the requirements
  function automatic void modelEvent(input logic [15:0] ns, input logic nb,
                                     output bit v, output logic [5:0] c);
    logic [15:0] r, f;
    r = ns & ~mPrev; f = ~ns & mPrev;
    v = 0; c = 0;
    if (nb != mPrevByp) begin v = 1; c = nb ? 6'd32 : 6'd0; return; end
    for (int s = 0; s < 16; s++) begin
      if (f[s]) begin v = 1; c = 0; return; end
      if (r[s] && {29'b0, mLvl[s]} > mMask) begin v = 1; c = 6'(16 + s); return; end
    end
  endfunction

  task automatic wrByte(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); busAddr = a; busWrData = d; busWrEn = 1;
    @(negedge clk); busWrEn = 0;
    modelWrite(a, d);
  endtask

  task automatic checkRead(input logic [4:0] a, input string tag);
    @(negedge clk); busAddr = a; busRdEn = 1;
    @(negedge clk); busRdEn = 0;
    check(busRdData == modelRead(a), tag, busRdData, modelRead(a));
  endtask

  task automatic drive(input logic [15:0] ns, input logic nb, input string tag);
    bit v; logic [5:0] c;
    modelEvent(ns, nb, v, c);
    @(negedge clk); srcIn = ns; bypassIn = nb;
    @(negedge clk);
    check(codeValid == v, {tag, " valid"}, codeValid, v);
    if (v) check(codeOut == c, {tag, " code"}, codeOut, c);
    mStatus &= ~(ns & ~mPrev);
    mPrev = ns; mPrevByp = nb;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired actual=0 expected=1");
    nFail++;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [7:0] held;
    void'($urandom(32'd1234));
    for (int s = 0; s < 16; s++) mLvl[s] = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(codeValid == 0, "R1 reset valid", codeValid, 0);
    for (int a = 0; a < 32; a++)
      checkRead(5'(a), (a >= 8 && a < 16) ? "R3 unmapped read" : "R1 reset value");

    // R2: level bytes keep only bits 2:0; byte lanes of the threshold
    for (int s = 0; s < 16; s++) wrByte(5'(16 + s), 8'($urandom));
    for (int s = 0; s < 16; s++) checkRead(5'(16 + s), "R2 level byte");
    wrByte(5'd5, 8'hA5); checkRead(5'd5, "R2 threshold lane1"); checkRead(5'd4, "R2 threshold lane0");
    wrByte(5'd5, 8'h00);

    // R5: qualifying and non-qualifying rises
    wrByte(5'd4, 8'd2); wrByte(5'd16, 8'd3); wrByte(5'd17, 8'd2);
    drive(16'h0001, 0, "R5 rise level above");
    drive(16'h0003, 0, "R5 rise level equal");
    checkRead(5'd0, "R4 pending cleared");
    wrByte(5'd0, 8'hFF); checkRead(5'd0, "R4 software set");
    drive(16'h0002, 0, "R7 source fall");

    // R6/R7 bypass
    wrByte(5'd4, 8'd7);
    drive(16'h0002, 1, "R6 bypass rise");
    drive(16'h0002, 0, "R7 bypass fall");

    // R11: high threshold byte blocks all
    wrByte(5'd4, 8'd0); wrByte(5'd5, 8'h01); wrByte(5'd21, 8'd7);
    drive(16'h0022, 0, "R11 upper threshold blocks");
    wrByte(5'd5, 8'h00);

    // R8: several at once
    wrByte(5'd19, 8'd5); wrByte(5'd25, 8'd6);
    drive(16'h0000, 0, "R8 clear all");
    drive(16'h0208, 0, "R8 lowest index");
    checkRead(5'd0, "R8 pending byte0"); checkRead(5'd1, "R8 pending byte1");
    drive(16'h0000, 0, "R8 falls");
    drive(16'h0008, 1, "R8 bypass first");

    // R9: write and rise on the same bit
    begin
      logic [15:0] ns; bit v; logic [5:0] c;
      ns = mPrev | 16'h0010;
      modelEvent(ns, mPrevByp, v, c);
      @(negedge clk); srcIn = ns; busAddr = 5'd0; busWrData = 8'hFF; busWrEn = 1;
      @(negedge clk); busWrEn = 0;
      check(codeValid == v, "R9 valid", codeValid, v);
      mStatus[7:0] = 8'hFF;
      mStatus &= ~(ns & ~mPrev);
      mPrev = ns;
      checkRead(5'd0, "R9 clear wins");
    end

    // R3: unmapped writes
    for (int a = 8; a < 16; a++) wrByte(5'(a), 8'hFF);
    for (int a = 4; a < 32; a++) checkRead(5'(a), "R3 no effect");

    // R10: read data holds
    checkRead(5'd16, "R10 load");
    held = busRdData;
    busAddr = 5'd4;
    repeat (3) @(negedge clk);
    check(busRdData == held, "R10 hold", busRdData, held);

    // random traffic
    for (int i = 0; i < 400; i++) begin
      if ($urandom % 3 == 0) wrByte(5'($urandom), 8'($urandom % 4 == 0 ? $urandom : $urandom % 8));
      else drive(mPrev ^ 16'($urandom & $urandom & $urandom),
                 ($urandom % 6 == 0) ? ~mPrevByp : mPrevByp, "R8 random");
    end
    for (int a = 0; a < 32; a++) checkRead(5'(a), "R2 final readback");

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule